// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes one instruction per clock cycle. It executes a nine-instruction subset of a classic three-operand load/store instruction set:

- register-to-register add, subtract, AND, OR and signed set-less-than
- load word and store word
- branch-if-equal
- absolute jump

Every instruction shares the same front end. The core fetches the word at the program counter and reads up to two registers named by fields of that word. A back end for each instruction class then finishes the work: an ALU result written back, a memory access, or a new program counter.

The core drives two separate memory ports, one for instructions and one for data. Both are combinational reads. The instruction port is addressed directly by the program counter. The data port is addressed by the ALU result, and a store is committed by the memory on the rising clock edge while the write strobe is high. The memories themselves sit outside the core.

The register file is 32 words of 32 bits. It has two read selects and one write select. A one-hot decoder raises the load enable of one register only, and the write data is presented to all of them.

Top module: `sc_core`

## Requirements
- R1: A high `rst` sampled on a rising edge sets the program counter, seen on `imem_addr`, to 0.
- R2: The opcode field is bits 31:26. After an R-type instruction (opcode 0x00), a load (0x23) or a store (0x2B), the next `imem_addr` is the current one plus 4.
- R3: An R-type instruction with funct (bits 5:0) 0x20 writes rs+rt into rd, and with funct 0x22 writes rs-rt into rd. The fields are rs = bits 25:21, rt = bits 20:16 and rd = bits 15:11.
- R4: An R-type instruction with funct 0x24 writes rs AND rt into rd, and with funct 0x25 writes rs OR rt into rd.
- R5: An R-type instruction with funct 0x2A writes 1 into rd when rs < rt as signed two's-complement values, and writes 0 otherwise, including when the two are equal.
- R6: A load (0x23) presents rs plus the sign-extended bits 15:0 on `dmem_addr`, and writes `dmem_rdata` into rt.
- R7: A store (0x2B) presents rs plus the sign-extended bits 15:0 on `dmem_addr`, and rt on `dmem_wdata`. `dmem_we` is high for a store and for nothing else.
- R8: Branch-if-equal (0x04) with rs equal to rt moves the program counter to PC+4 plus the sign-extended immediate shifted left by 2. With rs not equal to rt it moves to PC+4.
- R9: A jump (0x02) moves the program counter to bits 31:28 of PC+4, followed by bits 25:0 of the instruction, followed by two zero bits.
- R10: Register 0 reads as 0 at all times. A write that selects it has no effect.
- R11: An unknown opcode, or an R-type instruction with an unknown funct, writes no register and no memory, and advances the program counter by 4.
- R12: A register write changes only the selected destination register. Every other register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (the program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata | output | 32 | Store data (second register read) |
| dmem_we | output | 1 | Store strobe, committed on the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The assertions rely on the following properties of the environment:

- `imem_data` and `dmem_rdata` settle within the same cycle as their addresses.
- `imem_data` is always a known value once reset has been released.
- The checks on the next program counter also rely on reset staying low for the cycle that follows.

The stimulus keeps to these limits. Both memories are combinational arrays in the bench, filled before reset is released, and they wrap on address bits 7:2 so that every fetch returns a defined word. Reset is asserted only at the start of the run. The program reaches every instruction class, an unknown opcode, an unknown funct, both branch outcomes, writes that select register 0, and a negative offset. It ends in a self-branch loop so that the fetch address stays inside the program.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] OPC_JUMP  = 6'h02;
   localparam logic [5:0] OPC_BEQ   = 6'h04;
   localparam logic [5:0] OPC_LOAD  = 6'h23;
   localparam logic [5:0] OPC_STORE = 6'h2B;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_ADD,
      CLS_SUB,
      CLS_FUNCT
   } alu_cls_e;

   typedef struct packed {
      logic    reg_write;
      logic    dst_is_rd;
      logic    use_imm;
      logic    mem_write;
      logic    mem_to_reg;
      logic    branch;
      logic    jump;
      alu_op_e alu_op;
   } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   alu_cls_e cls;
   logic     main_rw;
   logic     funct_ok;
   alu_op_e  fn_op;

   // Main decode: one row per opcode
   always_comb begin
      ctrl    = '0;
      cls     = CLS_ADD;
      main_rw = 1'b0;
      unique case (opcode)
         OPC_RTYPE: begin
            main_rw        = 1'b1;
            ctrl.dst_is_rd = 1'b1;
            cls            = CLS_FUNCT;
         end
         OPC_LOAD: begin
            main_rw         = 1'b1;
            ctrl.use_imm    = 1'b1;
            ctrl.mem_to_reg = 1'b1;
         end
         OPC_STORE: begin
            ctrl.use_imm   = 1'b1;
            ctrl.mem_write = 1'b1;
         end
         OPC_BEQ: begin
            ctrl.branch = 1'b1;
            cls         = CLS_SUB;
         end
         OPC_JUMP: begin
            ctrl.jump = 1'b1;
         end
         default: ;
      endcase
      ctrl.alu_op    = (cls == CLS_FUNCT) ? fn_op :
                       (cls == CLS_SUB)   ? ALU_SUB : ALU_ADD;
      ctrl.reg_write = main_rw && ((cls != CLS_FUNCT) || funct_ok);
   end

   // ALU control: funct field refines R-type
   always_comb begin
      funct_ok = 1'b1;
      fn_op    = ALU_ADD;
      unique case (funct)
         FN_ADD: fn_op = ALU_ADD;
         FN_SUB: fn_op = ALU_SUB;
         FN_AND: fn_op = ALU_AND;
         FN_OR:  fn_op = ALU_OR;
         FN_SLT: fn_op = ALU_SLT;
         default: funct_ok = 1'b0;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] result,
   output logic             is_zero
);

   logic [WIDTH-1:0] diff;

   assign diff = op_a - op_b;

   always_comb begin
      unique case (op)
         ALU_ADD: result = op_a + op_b;
         ALU_SUB: result = diff;
         ALU_AND: result = op_a & op_b;
         ALU_OR:  result = op_a | op_b;
         ALU_SLT: result = {{(WIDTH-1){1'b0}}, ($signed(op_a) < $signed(op_b))};
         default: result = '0;
      endcase
   end

   assign is_zero = (result == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int WIDTH = 32,
   parameter int DEPTH = 32,
   localparam int SEL_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic [SEL_W-1:0] sel_a,
   input  logic [SEL_W-1:0] sel_b,
   output logic [WIDTH-1:0] data_a,
   output logic [WIDTH-1:0] data_b,
   input  logic             wr_en,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic [WIDTH-1:0] wr_data
);

   logic [DEPTH-1:0] load_en;
   logic [WIDTH-1:0] bank [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      assign load_en[g] = wr_en && (wr_sel == SEL_W'(g));
      if (g == 0) begin : g_zero
         assign bank[g] = '0;
      end else begin : g_store
         logic [WIDTH-1:0] q;
         always_ff @(posedge clk) begin
            if (load_en[g]) q <= wr_data;
         end
         assign bank[g] = q;
      end
   end

   assign data_a = bank[sel_a];
   assign data_b = bank[sel_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int NREGS = 32
) (
   input  logic            clk,
   input  logic            rst,
   output logic [XLEN-1:0] imem_addr,
   input  logic [31:0]     imem_data,
   output logic [XLEN-1:0] dmem_addr,
   output logic [XLEN-1:0] dmem_wdata,
   output logic            dmem_we,
   input  logic [XLEN-1:0] dmem_rdata
);

   localparam int SEL_W = $clog2(NREGS);
   localparam int IMM_W = 16;
   localparam int JF_W  = 26;

   if (XLEN != 32) begin : g_bad_xlen
      $error("sc_core: XLEN must be 32 for this encoding");
   end
   if (NREGS != 32 || SEL_W != 5) begin : g_bad_nregs
      $error("sc_core: NREGS must be 32 (5-bit register fields)");
   end

   logic [XLEN-1:0]  pc, pc_plus4, pc_next, br_target, jmp_target;
   logic [5:0]       opcode, funct;
   logic [SEL_W-1:0] f_rs, f_rt, f_rd, wr_sel;
   logic [XLEN-1:0]  imm_sx, rd_a, rd_b, alu_b, alu_y, wb_data;
   logic             alu_zero;
   ctrl_t            ctrl;
   logic             unused_shamt;

   assign opcode       = imem_data[31:26];
   assign f_rs         = imem_data[25:21];
   assign f_rt         = imem_data[20:16];
   assign f_rd         = imem_data[15:11];
   assign funct        = imem_data[5:0];
   assign unused_shamt = ^imem_data[10:6];
   assign imm_sx       = {{(XLEN-IMM_W){imem_data[IMM_W-1]}}, imem_data[IMM_W-1:0]};

   sc_decode i_decode (
      .opcode (opcode),
      .funct  (funct),
      .ctrl   (ctrl)
   );

   assign wr_sel  = ctrl.dst_is_rd ? f_rd : f_rt;
   assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;

   sc_regfile #(.WIDTH(XLEN), .DEPTH(NREGS)) i_regfile (
      .clk     (clk),
      .sel_a   (f_rs),
      .sel_b   (f_rt),
      .data_a  (rd_a),
      .data_b  (rd_b),
      .wr_en   (ctrl.reg_write),
      .wr_sel  (wr_sel),
      .wr_data (wb_data)
   );

   assign alu_b = ctrl.use_imm ? imm_sx : rd_b;

   sc_alu #(.WIDTH(XLEN)) i_alu (
      .op_a    (rd_a),
      .op_b    (alu_b),
      .op      (ctrl.alu_op),
      .result  (alu_y),
      .is_zero (alu_zero)
   );

   assign dmem_addr  = alu_y;
   assign dmem_wdata = rd_b;
   assign dmem_we    = ctrl.mem_write;

   // Next program counter
   assign pc_plus4   = pc + XLEN'(4);
   assign br_target  = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
   assign jmp_target = {pc_plus4[XLEN-1:XLEN-4], imem_data[JF_W-1:0], 2'b00};

   always_comb begin
      pc_next = pc_plus4;
      if (ctrl.jump)                     pc_next = jmp_target;
      else if (ctrl.branch && alu_zero)  pc_next = br_target;
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= '0;
      else     pc <= pc_next;
   end

   assign imem_addr = pc;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
#(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic [XLEN-1:0] imem_addr,
   input logic [31:0]     imem_data,
   input logic            dmem_we,
   input logic [XLEN-1:0] rs_val,
   input logic [XLEN-1:0] rt_val
);

   logic [5:0]      op;
   logic [XLEN-1:0] seq_pc, exp_br, exp_jmp;
   logic            known_op;

   assign op       = imem_data[31:26];
   assign seq_pc   = imem_addr + XLEN'(4);
   assign exp_br   = seq_pc + {{(XLEN-18){imem_data[15]}}, imem_data[15:0], 2'b00};
   assign exp_jmp  = {seq_pc[XLEN-1:XLEN-4], imem_data[25:0], 2'b00};
   assign known_op = (op == OPC_RTYPE) || (op == OPC_LOAD) || (op == OPC_STORE) ||
                     (op == OPC_BEQ)   || (op == OPC_JUMP);

   a_r1_reset_pc: assert property (@(posedge clk) rst |=> imem_addr == '0);

   a_r2_seq_next: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_RTYPE || op == OPC_LOAD || op == OPC_STORE)
         |=> imem_addr == $past(seq_pc));

   a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
      imem_addr[1:0] == 2'b00);

   a_r7_we_store: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> op == OPC_STORE);

   a_r7_store_we: assert property (@(posedge clk) disable iff (rst)
      op == OPC_STORE |-> dmem_we);

   a_r8_beq_taken: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_BEQ && rs_val == rt_val) |=> imem_addr == $past(exp_br));

   a_r8_beq_fall: assert property (@(posedge clk) disable iff (rst)
      (op == OPC_BEQ && rs_val != rt_val) |=> imem_addr == $past(seq_pc));

   a_r9_jump: assert property (@(posedge clk) disable iff (rst)
      op == OPC_JUMP |=> imem_addr == $past(exp_jmp));

   a_r10_zero_a: assert property (@(posedge clk) disable iff (rst)
      imem_data[25:21] == 5'd0 |-> rs_val == '0);

   a_r10_zero_b: assert property (@(posedge clk) disable iff (rst)
      imem_data[20:16] == 5'd0 |-> rt_val == '0);

   a_r11_unknown: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> !dmem_we ##1 imem_addr == $past(seq_pc));

endmodule

bind sc_core sc_core_chk #(.XLEN(XLEN)) i_chk (
   .clk       (clk),
   .rst       (rst),
   .imem_addr (imem_addr),
   .imem_data (imem_data),
   .dmem_we   (dmem_we),
   .rs_val    (rd_a),
   .rt_val    (rd_b)
);

// File: tb/test_sc_core.sv
module test_sc_core;

   localparam int CLK_P  = 10;
   localparam int NWORDS = 64;
   localparam int RUN    = 60;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
   logic        dmem_we;

   logic [31:0] imem [NWORDS];
   logic [31:0] dmem [NWORDS];

   int checks = 0;
   int errors = 0;

   // Reference model state
   logic [31:0] mreg [32];
   logic [31:0] mdm  [NWORDS];
   logic [31:0] mpc;
   string       mtag [32];
   int          mseq [32];
   int          wr_seq = 0;
   string       pc_tag = "R1";

   always #(CLK_P/2) clk = ~clk;

   sc_core i_sc_core (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_data  (imem_data),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_data  = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
   end

   function automatic logic [31:0] rtype(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] itype(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp, input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // Compare ports against the model, then advance the model by one instruction
   task automatic compare_and_step();
      logic [31:0] ins, sx, a, b, res, addr;
      logic [5:0]  op, fn;
      int          rs, rt, rd, dst;
      bit          wr;
      string       tg, rtag;

      chk(imem_addr === mpc, pc_tag, imem_addr, mpc, "program counter");
      ins = imem[mpc[7:2]];
      op  = ins[31:26];
      fn  = ins[5:0];
      rs  = int'(ins[25:21]);
      rt  = int'(ins[20:16]);
      rd  = int'(ins[15:11]);
      sx  = {{16{ins[15]}}, ins[15:0]};
      a   = mreg[rs];
      b   = mreg[rt];
      addr = a + sx;
      // R7: strobe only on store; R11: none on unknown opcodes
      chk(dmem_we === (op == 6'h2B), (op == 6'h2B || op == 6'h23) ? "R7" : "R11",
          32'(dmem_we), 32'(op == 6'h2B), "store strobe");
      if (op == 6'h23) chk(dmem_addr === addr, "R6", dmem_addr, addr, "load address");
      if (op == 6'h2B) begin
         chk(dmem_addr === addr, "R7", dmem_addr, addr, "store address");
         rtag = mtag[rt];
         if (rt != 0 && mseq[rt] != wr_seq) rtag = {rtag, " R12"};
         chk(dmem_wdata === b, rtag, dmem_wdata, b, "stored register value");
      end

      wr = 1'b0; dst = 0; res = '0; tg = "";
      mpc    = mpc + 4;
      pc_tag = "R2";
      case (op)
         6'h00: begin
            wr = 1'b1; dst = rd;
            case (fn)
               6'h20: begin res = a + b; tg = "R3"; end
               6'h22: begin res = a - b; tg = "R3"; end
               6'h24: begin res = a & b; tg = "R4"; end
               6'h25: begin res = a | b; tg = "R4"; end
               6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tg = "R5"; end
               default: begin wr = 1'b0; pc_tag = "R11"; end
            endcase
         end
         6'h23: begin wr = 1'b1; dst = rt; res = mdm[addr[7:2]]; tg = "R6"; end
         6'h2B: mdm[addr[7:2]] = b;
         6'h04: begin
            pc_tag = "R8";
            if (a == b) mpc = mpc + {sx[29:0], 2'b00};
         end
         6'h02: begin
            pc_tag = "R9";
            mpc = {mpc[31:28], ins[25:0], 2'b00};
         end
         default: pc_tag = "R11";
      endcase
      if (wr && dst != 0) begin
         wr_seq++;
         mreg[dst] = res;
         mtag[dst] = tg;
         mseq[dst] = wr_seq;
      end
   endtask

   initial begin
      for (int i = 0; i < NWORDS; i++) begin
         imem[i] = itype(6'h04, 0, 0, -1);   // self-loop filler
         dmem[i] = 32'h1357_0000 + 32'(i * 77);
      end
      dmem[0] = 32'd5;
      dmem[1] = 32'hFFFF_FFFD;   // -3
      dmem[2] = 32'h0F0F_00FF;
      dmem[3] = 32'h00FF_0F0F;
      dmem[4] = 32'd200;
      for (int i = 0; i < NWORDS; i++) mdm[i] = dmem[i];
      for (int i = 0; i < 32; i++) begin
         mreg[i] = '0; mtag[i] = "R10"; mseq[i] = 0;
      end

      imem[0]  = itype(6'h23, 0, 1, 0);
      imem[1]  = itype(6'h23, 0, 2, 4);
      imem[2]  = itype(6'h23, 0, 3, 8);
      imem[3]  = itype(6'h23, 0, 4, 12);
      imem[4]  = itype(6'h23, 0, 12, 16);
      imem[5]  = rtype(1, 2, 5, 6'h20);
      imem[6]  = rtype(1, 2, 6, 6'h22);
      imem[7]  = rtype(3, 4, 7, 6'h24);
      imem[8]  = rtype(3, 4, 8, 6'h25);
      imem[9]  = rtype(2, 1, 9, 6'h2A);    // -3 < 5
      imem[10] = rtype(1, 2, 10, 6'h2A);   // 5 < -3 false
      imem[11] = rtype(1, 1, 0, 6'h20);    // write to r0 (R10)
      imem[12] = itype(6'h23, 0, 0, 0);    // load into r0 (R10)
      imem[13] = itype(6'h2B, 0, 5, 128);
      imem[14] = itype(6'h2B, 0, 6, 132);
      imem[15] = itype(6'h2B, 0, 7, 136);
      imem[16] = itype(6'h2B, 0, 8, 140);
      imem[17] = itype(6'h2B, 0, 9, 144);
      imem[18] = itype(6'h2B, 0, 10, 148);
      imem[19] = itype(6'h2B, 12, 0, -4);  // negative offset
      imem[20] = itype(6'h23, 12, 11, -8);
      imem[21] = itype(6'h2B, 0, 11, 152);
      imem[22] = itype(6'h04, 1, 1, 1);    // taken
      imem[23] = rtype(1, 1, 13, 6'h20);   // skipped
      imem[24] = itype(6'h04, 1, 2, 1);    // not taken
      imem[25] = rtype(2, 2, 13, 6'h20);
      imem[26] = {6'h3F, 26'h0A5_5A5A};    // unknown opcode
      imem[27] = rtype(1, 1, 13, 6'h3F);   // unknown funct
      imem[28] = itype(6'h2B, 0, 13, 156);
      imem[29] = rtype(2, 2, 14, 6'h2A);   // equal operands
      imem[30] = itype(6'h2B, 0, 14, 160);
      imem[31] = {6'h02, 26'd33};          // jump to word 33
      imem[32] = rtype(1, 1, 13, 6'h20);   // skipped
      imem[33] = itype(6'h2B, 0, 1, 164);  // r1 untouched since load
      imem[34] = itype(6'h04, 0, 0, -1);   // self loop

      mpc = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: first fetch after reset at address 0
      for (int c = 0; c < RUN; c++) begin
         compare_and_step();
         @(negedge clk);
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule